// File: doc/BRIEF.md
# I2C Target Controller with Clock Stretching

This block is a byte-oriented I2C target. It oversamples the SCL and SDA bus lines on the system clock and drives each line through an open-drain pull-low output. It recognises Start, repeated Start and Stop, and takes the first byte after a Start as an address. That address is matched against a programmed 7-bit address, the general call address, or any address when a match-any mode is on.

A local host exchanges bytes with the bus through one data register. Two flags tell the host what happened: an address/stop flag and a data flag. Status bits give the transfer direction, the cause of the address/stop flag, the acknowledge received from the controller, whether SCL is being held, collisions and bus errors. While an address or data event waits for service, the block holds SCL low. This gives the host time to read a byte, load the next one, or choose the acknowledge value. A single response strobe clears the pending flag and lets the bus move on. The host can poll the flags, or treat them as interrupts.

Top module: `i2c_tgt_ctl`

## Requirements
- R1: After a Start, the target shifts in 8 bits MSB first on SCL rising edges. If bits 7..1 equal `own_addr_i`, it pulls SDA low for the 9th clock, places the whole byte in `rdata_o`, sets `flag_as_o` with `st_stop_o` = 0, and sets `st_dir_o` to bit 0 (1 = controller reads).
- R2: An address byte whose bits 7..1 are all zero (general call) is acknowledged and flagged in the same way as an own-address match.
- R3: With `match_any_i` = 1, every address byte is acknowledged, stored and flagged.
- R4: On an address mismatch, the target leaves SDA released for the 9th clock, raises no flag and leaves `rdata_o` unchanged. It ignores the bus until the next Start, and a following Stop raises no flag.
- R5: While `flag_as_o` (from an address) or `flag_data_o` is set, the target pulls SCL low once the controller has driven SCL low, and reports this on `st_hold_o`. One cycle after `resp_i` clears the flag, the target releases SCL. `resp_i` takes effect only while SCL is held, or while a Stop-caused flag is pending.
- R6: In a write transfer, each received byte goes into `rdata_o` and sets `flag_data_o`. On `resp_i`, the target drives the 9th bit as ACK (low) when `resp_nack_i` = 0, or as NACK when it is 1. After a NACK, further bytes are ignored until a Start or a Stop.
- R7: In a read transfer, the data register is sent MSB first. A controller ACK sets `flag_data_o` and clears `st_rxnack_o`, and the next byte is sent after `resp_i`. A controller NACK sets `st_rxnack_o`, raises no flag, and leaves SDA released.
- R8: A Stop that ends a transfer in which the target was addressed sets `flag_as_o` with `st_stop_o` = 1, without holding SCL. `resp_i` clears both.
- R9: A Start followed by a Stop with no SCL rising edge between them sets `st_berr_o`. The next Start clears it.
- R10: If the target releases SDA to send a 1 but samples SDA low on the SCL rising edge, it sets `st_coll_o` and drives nothing more until the next Start, which clears the bit.
- R11: After reset, both flags, all status bits, `rdata_o` and both pull outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_pull_o | output | 1 | 1 pulls SCL low |
| sda_pull_o | output | 1 | 1 pulls SDA low |
| own_addr_i | input | 7 | Programmed target address |
| match_any_i | input | 1 | Accept every address |
| host_wr_i | input | 1 | Load `host_wdata_i` into the data register |
| host_wdata_i | input | 8 | Byte to transmit |
| resp_i | input | 1 | Host response strobe: clear flag, release bus |
| resp_nack_i | input | 1 | With `resp_i` on a received byte: 1 = NACK |
| rdata_o | output | 8 | Data register contents |
| flag_as_o | output | 1 | Address/stop flag |
| flag_data_o | output | 1 | Data flag |
| st_dir_o | output | 1 | Received R/W bit |
| st_stop_o | output | 1 | Address/stop flag was caused by a Stop |
| st_rxnack_o | output | 1 | Last controller acknowledge was a NACK |
| st_hold_o | output | 1 | SCL is being held low |
| st_coll_o | output | 1 | Collision seen |
| st_berr_o | output | 1 | Bus error seen |

## Verification
The bench models the open-drain bus and raises SCL during a stretch, then checks that the line stays low until the response. A target that stretched too early or released without a response would let the controller clock data the host never saw. Address vectors cover own address, general call, match-any and near-miss addresses in both directions. A design that compared the R/W bit or stored rejected bytes would fail on these. Directed cases cover a Start followed directly by a Stop, a data NACK from the host followed by an ignored byte, and a read that ends in a controller NACK. They also cover a collision on a 1 bit, where a faulty target would keep driving the next, 0, bit onto the bus.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned ADDR_W = BYTE_W - 1;
  localparam int unsigned CNT_W  = $clog2(BYTE_W) + 1;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_RX,
    ST_RXHOLD,
    ST_RXACK,
    ST_TX,
    ST_TXACK,
    ST_TXHOLD,
    ST_WAIT
  } tgt_state_e;
endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic rst_sn,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [1:0]        rst_pipe;
  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_q;
  logic              sda_q;

  // reset asserts at once, leaves on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_q    <= scl_pipe[STAGES-1];
      sda_q    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s    = scl_pipe[STAGES-1];
  assign sda_s    = sda_pipe[STAGES-1];
  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_tgt_match.sv
module i2c_tgt_match
  import i2c_tgt_pkg::*;
(
  input  logic [BYTE_W-1:0] addr_byte,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              match_any,
  output logic              hit
);
  logic own_hit;
  logic gcall_hit;

  assign own_hit   = (addr_byte[BYTE_W-1:1] == own_addr);
  assign gcall_hit = (addr_byte[BYTE_W-1:1] == '0);
  assign hit       = match_any | own_hit | gcall_hit;
endmodule

// File: rtl/i2c_tgt_stretch.sv
module i2c_tgt_stretch (
  input  logic clk,
  input  logic rst_n,
  input  logic pend,
  input  logic scl_s,
  output logic scl_pull
);
  logic pull_d;

  // start holding only once the controller has taken SCL low
  always_comb pull_d = pend & (scl_pull | ~scl_s);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) scl_pull <= 1'b0;
    else        scl_pull <= pull_d;
  end

  AST_HOLD_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    scl_pull |-> $past(pend)) else $error("hold without flag"); // R5
endmodule

// File: rtl/i2c_tgt_ctl.sv
module i2c_tgt_ctl
  import i2c_tgt_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_pull_o,
  output logic              sda_pull_o,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              match_any_i,
  input  logic              host_wr_i,
  input  logic [BYTE_W-1:0] host_wdata_i,
  input  logic              resp_i,
  input  logic              resp_nack_i,
  output logic [BYTE_W-1:0] rdata_o,
  output logic              flag_as_o,
  output logic              flag_data_o,
  output logic              st_dir_o,
  output logic              st_stop_o,
  output logic              st_rxnack_o,
  output logic              st_hold_o,
  output logic              st_coll_o,
  output logic              st_berr_o
);
  logic rst_sn, scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic hit, scl_pull, pend, resp_ok, last_bit, addr_hit;
  logic [BYTE_W-1:0] byte_in;

  tgt_state_e        state_q, state_d;
  logic [CNT_W-1:0]  bitcnt_q, bitcnt_d;
  logic [BYTE_W-1:0] shreg_q, shreg_d, data_q, data_d;
  logic sda_q, sda_d, apf_q, apf_d, dif_q, dif_d, stopf_q, stopf_d;
  logic dir_q, dir_d, nacked_q, nacked_d, addressed_q, addressed_d;
  logic rxnack_q, rxnack_d, coll_q, coll_d, berr_q, berr_d;

  i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .rst_sn(rst_sn),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  assign byte_in  = {shreg_q[BYTE_W-2:0], sda_s};
  assign last_bit = (bitcnt_q == CNT_W'(BYTE_W - 1));

  i2c_tgt_match u_match (
    .addr_byte(byte_in), .own_addr(own_addr_i), .match_any(match_any_i), .hit(hit)
  );

  assign pend     = (apf_q & ~stopf_q) | dif_q;
  assign resp_ok  = resp_i & (scl_pull | (apf_q & stopf_q));
  assign addr_hit = (state_q == ST_ADDR) & scl_rise & last_bit & hit;

  i2c_tgt_stretch u_stretch (
    .clk(clk), .rst_n(rst_sn), .pend(pend), .scl_s(scl_s), .scl_pull(scl_pull)
  );

  always_comb begin
    state_d = state_q;  bitcnt_d = bitcnt_q;  shreg_d = shreg_q;  data_d = data_q;
    sda_d = sda_q;  apf_d = apf_q;  dif_d = dif_q;  stopf_d = stopf_q;  dir_d = dir_q;
    nacked_d = nacked_q;  addressed_d = addressed_q;  rxnack_d = rxnack_q;
    coll_d = coll_q;  berr_d = berr_q;
    if (host_wr_i) data_d = host_wdata_i;
    if (resp_ok) begin
      apf_d = 1'b0; dif_d = 1'b0; stopf_d = 1'b0;
    end
    case (state_q)
      ST_ADDR: if (scl_rise) begin
        shreg_d  = byte_in;
        bitcnt_d = bitcnt_q + CNT_W'(1);
        if (last_bit) begin
          if (hit) begin
            data_d = byte_in; dir_d = byte_in[0]; apf_d = 1'b1; stopf_d = 1'b0;
            addressed_d = 1'b1; state_d = ST_AACK;
          end else begin
            addressed_d = 1'b0; state_d = ST_WAIT;
          end
        end
      end
      ST_AACK: if (scl_fall) begin
        if (!sda_q) sda_d = 1'b1;
        else begin
          sda_d    = dir_q ? ~data_q[BYTE_W-1] : 1'b0;
          shreg_d  = {data_q[BYTE_W-2:0], 1'b0};
          bitcnt_d = '0;
          state_d  = dir_q ? ST_TX : ST_RX;
        end
      end
      ST_RX: if (scl_rise) begin
        shreg_d  = byte_in;
        bitcnt_d = bitcnt_q + CNT_W'(1);
        if (last_bit) begin
          data_d = byte_in; dif_d = 1'b1; state_d = ST_RXHOLD;
        end
      end
      ST_RXHOLD: if (resp_ok) begin
        sda_d = ~resp_nack_i; nacked_d = resp_nack_i; state_d = ST_RXACK;
      end
      ST_RXACK: if (scl_fall) begin
        sda_d = 1'b0; bitcnt_d = '0;
        state_d = nacked_q ? ST_WAIT : ST_RX;
      end
      ST_TX: begin
        if (scl_rise) begin
          if (!sda_q && !sda_s) begin
            coll_d = 1'b1; state_d = ST_WAIT;
          end else bitcnt_d = bitcnt_q + CNT_W'(1);
        end else if (scl_fall) begin
          if (bitcnt_q == CNT_W'(BYTE_W)) begin
            sda_d = 1'b0; state_d = ST_TXACK;
          end else begin
            sda_d   = ~shreg_q[BYTE_W-1];
            shreg_d = {shreg_q[BYTE_W-2:0], 1'b0};
          end
        end
      end
      ST_TXACK: if (scl_rise) begin
        rxnack_d = sda_s;
        if (sda_s) state_d = ST_WAIT;
        else begin
          dif_d = 1'b1; state_d = ST_TXHOLD;
        end
      end
      ST_TXHOLD: if (resp_ok) begin
        sda_d    = ~data_q[BYTE_W-1];
        shreg_d  = {data_q[BYTE_W-2:0], 1'b0};
        bitcnt_d = '0;
        state_d  = ST_TX;
      end
      default: ;
    endcase
    if (stop_ev) begin
      state_d = ST_IDLE; sda_d = 1'b0;
      if (state_q == ST_ADDR && bitcnt_q == '0) berr_d = 1'b1;
      if (addressed_q) begin
        apf_d = 1'b1; stopf_d = 1'b1; addressed_d = 1'b0;
      end
    end
    if (start_ev) begin
      state_d = ST_ADDR; bitcnt_d = '0; sda_d = 1'b0;
      berr_d = 1'b0; coll_d = 1'b0; rxnack_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      state_q <= ST_IDLE;  bitcnt_q <= '0;  shreg_q <= '0;  data_q <= '0;
      sda_q <= 1'b0;  apf_q <= 1'b0;  dif_q <= 1'b0;  stopf_q <= 1'b0;  dir_q <= 1'b0;
      nacked_q <= 1'b0;  addressed_q <= 1'b0;  rxnack_q <= 1'b0;
      coll_q <= 1'b0;  berr_q <= 1'b0;
    end else begin
      state_q <= state_d;  bitcnt_q <= bitcnt_d;  shreg_q <= shreg_d;  data_q <= data_d;
      sda_q <= sda_d;  apf_q <= apf_d;  dif_q <= dif_d;  stopf_q <= stopf_d;  dir_q <= dir_d;
      nacked_q <= nacked_d;  addressed_q <= addressed_d;  rxnack_q <= rxnack_d;
      coll_q <= coll_d;  berr_q <= berr_d;
    end
  end

  assign scl_pull_o  = scl_pull;
  assign sda_pull_o  = sda_q;
  assign rdata_o     = data_q;
  assign flag_as_o   = apf_q;
  assign flag_data_o = dif_q;
  assign st_dir_o    = dir_q;
  assign st_stop_o   = stopf_q;
  assign st_rxnack_o = rxnack_q;
  assign st_hold_o   = scl_pull;
  assign st_coll_o   = coll_q;
  assign st_berr_o   = berr_q;

  AST_APF_CAUSE: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(apf_q) |-> $past(stop_ev || addr_hit)) else $error("flag without cause"); // R1
  AST_BERR_AT_STOP: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(berr_q) |-> $past(stop_ev)) else $error("bus error without stop"); // R9
  AST_COLL_QUIET: assert property (@(posedge clk) disable iff (!rst_sn)
    coll_q |-> !sda_q) else $error("driving after collision"); // R10
  AST_WAIT_QUIET: assert property (@(posedge clk) disable iff (!rst_sn)
    (state_q == ST_WAIT) |-> !sda_q) else $error("driving while ignoring"); // R4
endmodule

// File: tb/tb_i2c_tgt_ctl.sv
module tb_i2c_tgt_ctl;
  localparam int Q = 8;
  localparam int LIMIT = 150000;
  // {own_addr[6:0], match_any, address byte[7:0], expect_ack}
  localparam logic [16:0] VEC [6] = '{
    {7'h42, 1'b0, 8'h84, 1'b1},
    {7'h42, 1'b0, 8'h85, 1'b1},
    {7'h42, 1'b0, 8'h86, 1'b0},
    {7'h42, 1'b0, 8'h00, 1'b1},
    {7'h10, 1'b1, 8'hEE, 1'b1},
    {7'h10, 1'b0, 8'hEE, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic m_scl, m_sda;
  logic scl, sda;
  logic scl_pull, sda_pull;
  logic [6:0] own;
  logic any, hwr, resp, rnack;
  logic [7:0] hdata, rdata;
  logic f_as, f_data, dir, stp, rxnack, hold, coll, berr;
  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  assign scl = m_scl & ~scl_pull;
  assign sda = m_sda & ~sda_pull;

  i2c_tgt_ctl dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda),
    .scl_pull_o(scl_pull), .sda_pull_o(sda_pull), .own_addr_i(own),
    .match_any_i(any), .host_wr_i(hwr), .host_wdata_i(hdata), .resp_i(resp),
    .resp_nack_i(rnack), .rdata_o(rdata), .flag_as_o(f_as), .flag_data_o(f_data),
    .st_dir_o(dir), .st_stop_o(stp), .st_rxnack_o(rxnack), .st_hold_o(hold),
    .st_coll_o(coll), .st_berr_o(berr)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc == LIMIT) begin
      errors++;
      $display("FAIL WDOG act=%0d exp=<%0d", cyc, LIMIT);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic qw(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_high();
    int n = 0;
    while (scl !== 1'b1 && n < 4000) begin
      @(negedge clk);
      n++;
    end
    if (n >= 4000) chk("R5 stretch never released", 0, 1);
  endtask

  task automatic m_start();
    m_sda = 1'b1; qw(Q);
    m_scl = 1'b1; wait_high(); qw(Q);
    m_sda = 1'b0; qw(Q);
    m_scl = 1'b0; qw(Q);
  endtask

  task automatic m_stop();
    m_sda = 1'b0; qw(Q);
    m_scl = 1'b1; wait_high(); qw(Q);
    m_sda = 1'b1; qw(Q);
  endtask

  task automatic m_bit(input logic b, output logic rb);
    m_sda = b; qw(Q);
    m_scl = 1'b1; wait_high(); qw(Q);
    rb = sda; qw(Q);
    m_scl = 1'b0; qw(Q);
  endtask

  task automatic m_send(input logic [7:0] d);
    logic rb;
    for (int k = 7; k >= 0; k--) m_bit(d[k], rb);
  endtask

  task automatic m_recv(output logic [7:0] d);
    logic rb;
    for (int k = 7; k >= 0; k--) begin
      m_bit(1'b1, rb);
      d[k] = rb;
    end
  endtask

  task automatic host_resp(input logic n);
    @(negedge clk); resp = 1'b1; rnack = n;
    @(negedge clk); resp = 1'b0; rnack = 1'b0;
  endtask

  task automatic host_load(input logic [7:0] d);
    @(negedge clk); hwr = 1'b1; hdata = d;
    @(negedge clk); hwr = 1'b0;
  endtask

  task automatic stop_flag(input string tag);
    qw(2 * Q);
    chk({tag, " R8 stop flag"}, {f_as, stp, hold}, 3'b110);
    host_resp(1'b0);
    qw(2);
    chk({tag, " R8 stop flag cleared"}, {f_as, stp}, 2'b00);
  endtask

  initial begin
    logic rb;
    logic [7:0] d;
    rst_n = 1'b0; m_scl = 1'b1; m_sda = 1'b1; own = 7'h42; any = 1'b0;
    hwr = 1'b0; hdata = '0; resp = 1'b0; rnack = 1'b0;
    qw(5);
    rst_n = 1'b1;
    qw(5);
    chk("R11 reset flags", {f_as, f_data, scl_pull, sda_pull}, 4'b0);
    chk("R11 reset status", {dir, stp, rxnack, hold, coll, berr}, 6'b0);
    chk("R11 reset data", rdata, 8'h00);

    // address recognition table (R1 own, R2 general call, R3 any, R4 miss)
    for (int i = 0; i < 6; i++) begin
      logic [16:0] v;
      v = VEC[i];
      own = v[16:10]; any = v[9];
      host_load(8'h5A);
      m_start();
      m_send(v[8:1]);
      qw(2 * Q);
      chk($sformatf("R1 R2 R3 R4 vec%0d flag", i), f_as, v[0]);
      chk($sformatf("R1 R4 vec%0d data", i), rdata, v[0] ? {24'h0, v[8:1]} : 32'h5A);
      if (v[0]) begin
        chk($sformatf("R1 vec%0d dir", i), dir, v[1]);
        chk($sformatf("R5 vec%0d hold", i), {hold, scl}, 2'b10);
        if (v[1]) host_load(8'hA5);
        host_resp(1'b0);
        m_bit(1'b1, rb);
        chk($sformatf("R1 vec%0d ack", i), rb, 1'b0);
        if (v[1]) begin
          m_recv(d);
          chk($sformatf("R7 vec%0d read byte", i), d, 8'hA5);
          m_bit(1'b1, rb);
          qw(2);
          chk($sformatf("R7 vec%0d nack", i), {rxnack, f_data, sda_pull}, 3'b100);
        end
        m_stop();
        stop_flag($sformatf("vec%0d", i));
      end else begin
        m_bit(1'b1, rb);
        chk($sformatf("R4 vec%0d no ack", i), rb, 1'b1);
        m_stop();
        qw(2 * Q);
        chk($sformatf("R4 vec%0d no stop flag", i), f_as, 1'b0);
      end
    end
    own = 7'h42; any = 1'b0;

    // write transfer with ACK, NACK, then an ignored byte (R5, R6)
    m_start();
    m_send(8'h84);
    qw(2 * Q);
    host_resp(1'b0);
    m_bit(1'b1, rb);
    m_send(8'h3C);
    qw(2 * Q);
    chk("R6 data flag", {f_data, rdata}, {1'b1, 8'h3C});
    m_sda = 1'b1; m_scl = 1'b1;
    qw(3 * Q);
    chk("R5 scl held against controller", {hold, scl}, 2'b10);
    host_resp(1'b0);
    qw(2);
    chk("R5 released after response", hold, 1'b0);
    wait_high(); qw(Q);
    rb = sda; qw(Q);
    m_scl = 1'b0; qw(Q);
    chk("R6 ack driven", rb, 1'b0);
    m_send(8'hC3);
    qw(2 * Q);
    chk("R6 second byte", rdata, 8'hC3);
    host_resp(1'b1);
    m_bit(1'b1, rb);
    chk("R6 nack driven", rb, 1'b1);
    m_send(8'h00);
    qw(2 * Q);
    chk("R6 ignored after nack", {f_data, hold, rdata}, {2'b00, 8'hC3});
    m_bit(1'b1, rb);
    chk("R6 ignored byte not acked", rb, 1'b1);
    m_stop();
    stop_flag("write");

    // read transfer: controller ACK then NACK (R7)
    m_start();
    m_send(8'h85);
    qw(2 * Q);
    host_load(8'h96);
    host_resp(1'b0);
    m_bit(1'b1, rb);
    m_recv(d);
    chk("R7 first byte MSB first", d, 8'h96);
    m_bit(1'b0, rb);
    qw(2 * Q);
    chk("R7 ack sets data flag", {f_data, rxnack, hold}, 3'b101);
    host_load(8'h3A);
    host_resp(1'b0);
    m_recv(d);
    chk("R7 second byte", d, 8'h3A);
    m_bit(1'b1, rb);
    qw(2 * Q);
    chk("R7 nack no flag", {f_data, rxnack, hold}, 3'b010);
    m_stop();
    stop_flag("read");

    // bus error: Start then Stop with no clock (R9)
    m_sda = 1'b0; qw(Q);
    m_sda = 1'b1; qw(2 * Q);
    chk("R9 bus error set", {berr, f_as}, 2'b10);
    m_start();
    qw(2);
    chk("R9 cleared by start", berr, 1'b0);
    m_stop();
    qw(2 * Q);
    chk("R9 clocked stop no error", berr, 1'b0);

    // collision on a 1 bit (R10)
    m_start();
    m_send(8'h85);
    qw(2 * Q);
    host_load(8'hBF);
    host_resp(1'b0);
    m_bit(1'b1, rb);
    m_bit(1'b0, rb);
    qw(2);
    chk("R10 collision flagged", coll, 1'b1);
    m_bit(1'b1, rb);
    chk("R10 zero bit not driven", rb, 1'b1);
    for (int k = 0; k < 6; k++) m_bit(1'b1, rb);
    m_bit(1'b1, rb);
    chk("R10 bus left alone", {sda_pull, f_data}, 2'b00);
    m_stop();
    stop_flag("collision");
    m_start();
    qw(2);
    chk("R10 cleared by start", coll, 1'b0);
    m_stop();
    qw(2 * Q);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule